// File: doc/BRIEF.md
# Parallel Clause Evaluator with Shift-Register Clause State

This block tracks the truth state of a bank of CNF clauses while a search engine assigns Boolean variables one at a time. Before solving, an effect table is written into on-chip storage. It holds one word per variable. For every clause, the word says whether the variable is absent from it, appears as a positive literal, or appears as a negative literal. A new problem instance therefore needs only a table reload and no new logic.

Each clause keeps a one-hot token in a short shift register, plus a small count of satisfying assignments. The token position is the number of literals still open. A falsifying assignment moves the token one place toward position 0. A satisfying assignment moves it one place the other way and raises the satisfier count. A variable absent from the clause leaves it alone. An unassign strobe with the same variable and value applies the inverse move, so the search can back out assignments in reverse order. The block reports per-clause satisfied, conflict and unit flags, a global conflict flag, and an all-satisfied flag.

Top module: `sat_clause_eval`

## Requirements
- R1: A write with `load_we` high stores `load_word` as the effect word of variable `load_var`. Clause c uses bits [2c+1:2c]: 2'b00 means absent, 2'b01 means a true value satisfies the clause, and 2'b10 means a false value satisfies it. A later `init` or assign of that variable uses the stored word.
- R2: An `init` pulse places each clause token at that clause's literal count (the number of 01 or 10 codes in its column, clamped to MAX_LITS) and clears its satisfier count. A clause with one literal then reads unit, a clause with none reads conflict, and no clause reads satisfied.
- R3: An assign whose value satisfies clause c raises `clause_sat[c]` on the next clock edge. While the satisfier count is nonzero, `clause_unit[c]` and `clause_conf[c]` stay low.
- R4: An assign whose value falsifies a literal of clause c lowers its open-literal count by one. With no satisfier, one open literal gives `clause_unit[c]=1` and zero open literals gives `clause_conf[c]=1`.
- R5: An assign or unassign of a variable whose code for clause c is 2'b00 leaves all flags of clause c unchanged.
- R6: An unassign with the same variable and value as the most recent live assign restores every clause flag to its value before that assign.
- R7: `any_conflict` is the OR of all `clause_conf` bits, and `all_sat` is the AND of all `clause_sat` bits.
- R8: When `assign_vld` and `unassign_vld` are high in the same cycle, neither takes effect. `init` takes priority over both.
- R9: After reset the table is all-absent, every token sits at position 0 and no clause is satisfied. All `clause_conf` bits read 1, `clause_sat` and `clause_unit` read 0, `any_conflict` reads 1 and `all_sat` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_we | input | 1 | Effect table write strobe |
| load_var | input | VAR_W | Variable whose effect word is written |
| load_word | input | 2*NUM_CLAUSES | Effect word, 2 bits per clause |
| init | input | 1 | Reload tokens from literal counts |
| assign_vld | input | 1 | Apply an assignment of `var_idx` |
| unassign_vld | input | 1 | Undo an assignment of `var_idx` |
| var_idx | input | VAR_W | Variable being assigned or unassigned |
| var_val | input | 1 | Value of that variable |
| clause_sat | output | NUM_CLAUSES | Per-clause satisfied flag |
| clause_conf | output | NUM_CLAUSES | Per-clause conflict flag |
| clause_unit | output | NUM_CLAUSES | Per-clause unit flag |
| any_conflict | output | 1 | OR of conflict flags |
| all_sat | output | 1 | AND of satisfied flags |

## Verification
Directed cases drive a two-literal clause through each state in turn: open, then unit, then conflict, then back by undo, then satisfied. These cases separate a move toward position 0 from a move away from it, and each move from its inverse. A variable absent from a clause and a simultaneous assign and unassign show that nothing moves when nothing should. Random instances with up to MAX_LITS literals per clause are then searched with random assigns and stack-ordered undos. After every step, all flags are compared against a counting model. This catches swapped polarity codes, a wrong literal count at init, and an undo that does not exactly invert its move.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam logic [1:0] EFF_ABSENT = 2'b00;
    localparam logic [1:0] EFF_POS    = 2'b01;
    localparam logic [1:0] EFF_NEG    = 2'b10;

    // Token moves: "up" is away from position 0, "down" toward it.
    typedef enum logic [2:0] {
        SH_HOLD    = 3'd0,
        SH_SAT     = 3'd1,  // up,   satisfier count +1
        SH_FAL     = 3'd2,  // down
        SH_UNSAT   = 3'd3,  // down, satisfier count -1
        SH_UNFAL   = 3'd4   // up
    } shift_e;

    function automatic shift_e decode_move(logic [1:0] code, logic val, logic undo);
        logic is_sat;
        logic is_fal;
        is_sat = (code == EFF_POS && val) || (code == EFF_NEG && !val);
        is_fal = (code == EFF_POS && !val) || (code == EFF_NEG && val);
        if (is_sat) return undo ? SH_UNSAT : SH_SAT;
        if (is_fal) return undo ? SH_UNFAL : SH_FAL;
        return SH_HOLD;
    endfunction

endpackage

// File: rtl/sat_effect_mem.sv
module sat_effect_mem
    import sat_pkg::*;
#(
    parameter int NUM_VARS    = 16,
    parameter int NUM_CLAUSES = 8,
    parameter int MAX_LITS    = 4,
    localparam int VAR_W  = $clog2(NUM_VARS),
    localparam int WORD_W = 2 * NUM_CLAUSES,
    localparam int CNT_W  = $clog2(MAX_LITS + 1),
    localparam int SUM_W  = $clog2(NUM_VARS + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [VAR_W-1:0]                    waddr_i,
    input  logic [WORD_W-1:0]                   wdata_i,
    input  logic [VAR_W-1:0]                    raddr_i,
    output logic [WORD_W-1:0]                   rdata_o,
    output logic [NUM_CLAUSES-1:0][CNT_W-1:0]   lit_cnt_o
);

    typedef logic [NUM_VARS-1:0][WORD_W-1:0] table_t;

    table_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_count
        logic [SUM_W-1:0] sum;
        always_comb begin
            sum = '0;
            for (int v = 0; v < NUM_VARS; v++) begin
                if (mem_q[v][2*c +: 2] == EFF_POS || mem_q[v][2*c +: 2] == EFF_NEG) begin
                    sum = sum + SUM_W'(1);
                end
            end
            if (sum > SUM_W'(MAX_LITS)) begin
                lit_cnt_o[c] = CNT_W'(MAX_LITS);
            end else begin
                lit_cnt_o[c] = CNT_W'(sum);
            end
        end
    end

    // R1: a write lands in the addressed entry
    p_load_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> lit_cnt_o[0] <= CNT_W'(MAX_LITS));

endmodule

// File: rtl/sat_move_decode.sv
module sat_move_decode
    import sat_pkg::*;
#(
    parameter int NUM_CLAUSES = 8,
    localparam int WORD_W = 2 * NUM_CLAUSES
) (
    input  logic [WORD_W-1:0]            eff_word_i,
    input  logic                         val_i,
    input  logic                         assign_i,
    input  logic                         unassign_i,
    output shift_e [NUM_CLAUSES-1:0]     move_o
);

    logic active;
    assign active = assign_i ^ unassign_i;

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_dec
        always_comb begin
            if (active) begin
                move_o[c] = decode_move(eff_word_i[2*c +: 2], val_i, unassign_i);
            end else begin
                move_o[c] = SH_HOLD;
            end
        end
    end

endmodule

// File: rtl/sat_clause_cell.sv
module sat_clause_cell
    import sat_pkg::*;
#(
    parameter int MAX_LITS = 4,
    localparam int CNT_W = $clog2(MAX_LITS + 1),
    localparam int TOK_W = 2 * MAX_LITS + 1,
    localparam int SC_W  = $clog2(MAX_LITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [CNT_W-1:0] lit_cnt_i,
    input  shift_e           move_i,
    output logic             sat_o,
    output logic             conf_o,
    output logic             unit_o
);

    typedef struct packed {
        logic [TOK_W-1:0] tok;
        logic [SC_W-1:0]  nsat;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d.tok  = TOK_W'(1) << lit_cnt_i;
            st_d.nsat = '0;
        end else begin
            unique case (move_i)
                SH_SAT: begin
                    if (!st_q.tok[TOK_W-1]) st_d.tok = st_q.tok << 1;
                    if (st_q.nsat != SC_W'(MAX_LITS)) st_d.nsat = st_q.nsat + SC_W'(1);
                end
                SH_UNFAL: begin
                    if (!st_q.tok[TOK_W-1]) st_d.tok = st_q.tok << 1;
                end
                SH_FAL: begin
                    if (!st_q.tok[0]) st_d.tok = st_q.tok >> 1;
                end
                SH_UNSAT: begin
                    if (!st_q.tok[0]) st_d.tok = st_q.tok >> 1;
                    if (st_q.nsat != '0) st_d.nsat = st_q.nsat - SC_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tok  <= TOK_W'(1);
            st_q.nsat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sat_o  = (st_q.nsat != '0);
    assign conf_o = st_q.tok[0];
    assign unit_o = st_q.tok[1] && (st_q.nsat == '0);

    p_token_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> $onehot(st_q.tok));

    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !sat_o);

    p_sat_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && move_i == SH_SAT) |=> sat_o && !unit_o && !conf_o);

    p_conf_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conf_o |-> !sat_o && !unit_o);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && move_i == SH_HOLD) |=> $stable(sat_o) && $stable(conf_o) && $stable(unit_o));

endmodule

// File: rtl/sat_clause_eval.sv
module sat_clause_eval
    import sat_pkg::*;
#(
    parameter int NUM_VARS    = 16,
    parameter int NUM_CLAUSES = 8,
    parameter int MAX_LITS    = 4,
    localparam int VAR_W  = $clog2(NUM_VARS),
    localparam int WORD_W = 2 * NUM_CLAUSES,
    localparam int CNT_W  = $clog2(MAX_LITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_we,
    input  logic [VAR_W-1:0]        load_var,
    input  logic [WORD_W-1:0]       load_word,
    input  logic                    init,
    input  logic                    assign_vld,
    input  logic                    unassign_vld,
    input  logic [VAR_W-1:0]        var_idx,
    input  logic                    var_val,
    output logic [NUM_CLAUSES-1:0]  clause_sat,
    output logic [NUM_CLAUSES-1:0]  clause_conf,
    output logic [NUM_CLAUSES-1:0]  clause_unit,
    output logic                    any_conflict,
    output logic                    all_sat
);

    logic [WORD_W-1:0]                   eff_word;
    logic [NUM_CLAUSES-1:0][CNT_W-1:0]   lit_cnt;
    shift_e [NUM_CLAUSES-1:0]            move;

    sat_effect_mem #(
        .NUM_VARS    (NUM_VARS),
        .NUM_CLAUSES (NUM_CLAUSES),
        .MAX_LITS    (MAX_LITS)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (load_we),
        .waddr_i   (load_var),
        .wdata_i   (load_word),
        .raddr_i   (var_idx),
        .rdata_o   (eff_word),
        .lit_cnt_o (lit_cnt)
    );

    sat_move_decode #(
        .NUM_CLAUSES (NUM_CLAUSES)
    ) u_dec (
        .eff_word_i (eff_word),
        .val_i      (var_val),
        .assign_i   (assign_vld),
        .unassign_i (unassign_vld),
        .move_o     (move)
    );

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_cell
        sat_clause_cell #(
            .MAX_LITS (MAX_LITS)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_i    (init),
            .lit_cnt_i (lit_cnt[c]),
            .move_i    (move[c]),
            .sat_o     (clause_sat[c]),
            .conf_o    (clause_conf[c]),
            .unit_o    (clause_unit[c])
        );
    end

    assign any_conflict = |clause_conf;
    assign all_sat      = &clause_sat;

    p_conf_blocks_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_conflict |-> !all_sat);

    p_pair_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (assign_vld && unassign_vld && !init) |=>
            $stable(clause_sat) && $stable(clause_conf) && $stable(clause_unit));

endmodule

// File: tb/sat_clause_eval_bench.sv
module sat_clause_eval_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    localparam int NC = 8;
    localparam int ML = 4;
    localparam int VW = $clog2(NV);
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_we = 1'b0;
    logic [VW-1:0] load_var = '0;
    logic [2*NC-1:0] load_word = '0;
    logic init = 1'b0;
    logic assign_vld = 1'b0;
    logic unassign_vld = 1'b0;
    logic [VW-1:0] var_idx = '0;
    logic var_val = 1'b0;
    logic [NC-1:0] clause_sat, clause_conf, clause_unit;
    logic any_conflict, all_sat;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int mcode [NV][NC];
    int mlen [NC];
    int mfal [NC];
    int msat [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_clause_eval #(.NUM_VARS(NV), .NUM_CLAUSES(NC), .MAX_LITS(ML)) u_sat_clause_eval (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_var(load_var),
        .load_word(load_word), .init(init), .assign_vld(assign_vld),
        .unassign_vld(unassign_vld), .var_idx(var_idx), .var_val(var_val),
        .clause_sat(clause_sat), .clause_conf(clause_conf), .clause_unit(clause_unit),
        .any_conflict(any_conflict), .all_sat(all_sat)
    );

    function automatic logic [2*NC-1:0] word_of(int v);
        logic [2*NC-1:0] w = '0;
        for (int c = 0; c < NC; c++) w[2*c +: 2] = 2'(mcode[v][c]);
        return w;
    endfunction

    task automatic check_all(string tag);
        logic [NC-1:0] es, ec, eu;
        logic ea, eall;
        for (int c = 0; c < NC; c++) begin
            es[c] = msat[c] > 0;
            ec[c] = (msat[c] == 0) && (mfal[c] == mlen[c]);
            eu[c] = (msat[c] == 0) && (mlen[c] - mfal[c] == 1);
        end
        ea = |ec;
        eall = &es;
        n_checks++;
        if (clause_sat !== es || clause_conf !== ec || clause_unit !== eu) begin
            n_fail++;
            $display("FAIL %s: sat/conf/unit=%b/%b/%b expected %b/%b/%b",
                     tag, clause_sat, clause_conf, clause_unit, es, ec, eu);
        end
        n_checks++;
        if (any_conflict !== ea || all_sat !== eall) begin
            n_fail++;
            $display("FAIL R7 (%s): any_conflict/all_sat=%b/%b expected %b/%b",
                     tag, any_conflict, all_sat, ea, eall);
        end
    endtask

    task automatic finish_step();
        @(negedge clk);
        load_we = 1'b0; init = 1'b0; assign_vld = 1'b0; unassign_vld = 1'b0;
    endtask

    task automatic do_load(int v);
        @(negedge clk);
        load_we = 1'b1; load_var = VW'(v); load_word = word_of(v);
        finish_step();
    endtask

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        finish_step();
        for (int c = 0; c < NC; c++) begin
            mlen[c] = 0; mfal[c] = 0; msat[c] = 0;
            for (int v = 0; v < NV; v++) if (mcode[v][c] == 1 || mcode[v][c] == 2) mlen[c]++;
            if (mlen[c] > ML) mlen[c] = ML;
        end
    endtask

    task automatic model_move(int v, bit val, bit undo);
        for (int c = 0; c < NC; c++) begin
            bit s = (mcode[v][c] == 1 && val) || (mcode[v][c] == 2 && !val);
            bit f = (mcode[v][c] == 1 && !val) || (mcode[v][c] == 2 && val);
            int d = undo ? -1 : 1;
            if (s) msat[c] += d;
            if (f) mfal[c] += d;
        end
    endtask

    task automatic do_move(int v, bit val, bit undo);
        @(negedge clk);
        var_idx = VW'(v); var_val = val;
        assign_vld = !undo; unassign_vld = undo;
        finish_step();
        model_move(v, val, undo);
    endtask

    task automatic clear_model();
        for (int v = 0; v < NV; v++) for (int c = 0; c < NC; c++) mcode[v][c] = 0;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int stk_v [NV];
        bit stk_b [NV];
        bit used [NV];
        int sp;
        void'($urandom(32'd4242));
        clear_model();
        for (int c = 0; c < NC; c++) begin mlen[c] = 0; mfal[c] = 0; msat[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset state");

        // Directed: clause 0 = (x0 | !x1); clause 2 = (x3); var 5 absent everywhere
        mcode[0][0] = 1; mcode[1][0] = 2; mcode[3][2] = 1;
        do_load(0); do_load(1); do_load(3);
        do_init();
        check_all("R1 R2 init from loaded table");
        do_move(5, 1'b1, 1'b0);
        check_all("R5 absent variable");
        do_move(0, 1'b0, 1'b0);
        check_all("R4 falsify to unit");
        do_move(1, 1'b1, 1'b0);
        check_all("R4 falsify to conflict");
        @(negedge clk);
        var_idx = VW'(1); var_val = 1'b0; assign_vld = 1'b1; unassign_vld = 1'b1;
        finish_step();
        check_all("R8 assign with unassign ignored");
        do_move(1, 1'b1, 1'b1);
        check_all("R6 undo conflict");
        do_move(1, 1'b0, 1'b0);
        check_all("R3 satisfy");
        do_move(3, 1'b1, 1'b0);
        check_all("R3 satisfy unit clause");
        @(negedge clk);
        init = 1'b1; assign_vld = 1'b1; var_idx = VW'(0); var_val = 1'b1;
        finish_step();
        for (int c = 0; c < NC; c++) begin mfal[c] = 0; msat[c] = 0; end
        check_all("R8 init priority");

        // Random instances with stack-ordered search
        for (int round = 0; round < 12; round++) begin
            clear_model();
            for (int c = 0; c < NC; c++) begin
                int cnt = 0;
                for (int v = 0; v < NV; v++) begin
                    int r = int'($urandom % 8);
                    if (cnt < ML && (r == 1 || r == 2)) begin
                        mcode[v][c] = r; cnt++;
                    end
                end
            end
            for (int v = 0; v < NV; v++) do_load(v);
            do_init();
            check_all("R2 random init");
            sp = 0;
            for (int v = 0; v < NV; v++) used[v] = 1'b0;
            for (int step = 0; step < 60; step++) begin
                if (sp > 0 && (sp == NV || ($urandom % 3) == 0)) begin
                    sp--;
                    used[stk_v[sp]] = 1'b0;
                    do_move(stk_v[sp], stk_b[sp], 1'b1);
                    check_all("R6 random undo");
                end else begin
                    int v = int'($urandom % NV);
                    while (used[v]) v = (v + 1) % NV;
                    stk_v[sp] = v; stk_b[sp] = 1'($urandom % 2);
                    used[v] = 1'b1;
                    do_move(v, stk_b[sp], 1'b0);
                    sp++;
                    check_all("R3 R4 R5 random assign");
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule